// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital mode controller of a LIN bus interface node. It takes digitised status inputs: supply present, regulator undervoltage, the host's enable and transmit-data pins, and a bus wake-up request. From these it decides which of five operating modes the node is in. For the current mode it drives the regulator enable, the transmitter and receiver path enables, the open-drain reset output to the host, and an override that pulls the host's receive-data line low.

After power-up the host is held in reset for a programmable number of clock ticks. It then moves the node into normal operation by raising its enable pin. When the host drops enable, the block waits for a short select window and then samples transmit data. If transmit data is high at that point, the node goes to a low-power listening mode that keeps the regulator on. If it is low, the node goes to a deep sleep mode that turns the regulator off.

A bus wake-up request brings the node back to fail-safe and flags the host through the receive line. A debounced regulator undervoltage, or a loss of supply, overrides every other condition.

Top module: `lin_mode_ctrl`

## Requirements
- R1: With `supply_ok_i` high in the unpowered mode, the next clock enters fail-safe. In fail-safe the regulator is enabled and `nres_o` is low.
- R2: `supply_ok_i` low in any mode gives the unpowered mode on the next clock. In that mode every enable is off, `nres_o` is low, and the wake flag is cleared.
- R3: In fail-safe, `nres_o` stays low until RST_TICKS consecutive clocks have passed with `vcc_uv_i` low. Any clock with `vcc_uv_i` high restarts this count.
- R4: While the reset hold of R3 is running, a high enable does not cause a mode change.
- R5: In fail-safe, once the hold has expired, `vcc_uv_i` is low and the synchronised enable is high, the node enters normal mode. Normal mode sets `tx_en_o` and `rx_en_o`.
- R6: In normal mode, a falling synchronised enable opens a select window of SEL_TICKS clocks with `tx_en_o` low. If synchronised TXD is high when the window ends, the node enters silent mode: regulator on, transmitter and receiver off, `nres_o` high.
- R7: If synchronised TXD is low when the window ends, the node enters sleep mode: regulator off, `nres_o` low, `rxd_low_o` high. TXD may fall later than enable, as long as it falls inside the window.
- R8: If enable returns high inside the select window, the window is cancelled. The node stays in normal mode and `tx_en_o` returns high.
- R9: In normal or silent mode, `vcc_uv_i` high on UV_TICKS consecutive clocks forces fail-safe with a fresh reset hold. Shorter pulses have no effect.
- R10: A wake request in silent mode enters fail-safe with `rxd_low_o` high and `nres_o` still high. Entering normal mode clears `rxd_low_o`.
- R11: A wake request in sleep mode enters fail-safe with the regulator on, `rxd_low_o` high and a fresh reset hold. If enable is high after the hold, the node goes on to normal mode.
- R12: Enable and TXD each pass through a SYNC_STAGES-flop synchroniser that resets to enable low and TXD high. `mode_o` is encoded as 0 unpowered, 1 fail-safe, 2 normal, 3 silent, 4 sleep.
- R13: A high enable in silent mode returns the node to normal mode. A high enable in sleep mode enters fail-safe with a fresh reset hold and without the wake flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Battery supply above its undervoltage threshold |
| vcc_uv_i | input | 1 | Regulator output below its undervoltage threshold |
| en_i | input | 1 | Host enable pin, asynchronous |
| txd_i | input | 1 | Host transmit data pin, asynchronous |
| wake_req_i | input | 1 | Filtered bus wake-up request |
| mode_o | output | 3 | Current mode code |
| reg_en_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Bus transmitter enable |
| rx_en_o | output | 1 | Receive path enable |
| nres_o | output | 1 | Host reset, low active |
| rxd_low_o | output | 1 | Force host receive line low |

## Verification
Some rules are checked by the assertions on every cycle:
- supply loss drops the node to unpowered;
- power-up lands in fail-safe with reset asserted;
- the transmitter is enabled only in normal mode;
- the sleep-mode outputs are fixed;
- normal mode cannot be entered while the hold runs;
- a high enable cancels the select window;
- a silent-mode wake keeps reset released.

Other behaviour only the bench scenarios can show, by comparing every clock against a behavioural model:
- how long the reset hold lasts, and how it restarts;
- the exact clock on which the select window decides;
- TXD falling after enable but still inside the window;
- undervoltage pulses that are too short to trip the debounce.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_SAFE  = 3'd1,
    MODE_RUN   = 3'd2,
    MODE_QUIET = 3'd3,
    MODE_DOZE  = 3'd4
  } lin_mode_e;
endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= RST_VAL;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lin_reset_timer.sv
module lin_reset_timer #(
  parameter int RST_TICKS = 4000,
  parameter int UV_TICKS  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clear_i,
  input  logic in_safe_i,
  input  logic uv_watch_i,
  input  logic vcc_uv_i,
  output logic hold_done_o,
  output logic uv_trip_o
);
  localparam int HOLD_W = $clog2(RST_TICKS + 1);
  localparam int UV_W   = $clog2(UV_TICKS + 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(RST_TICKS);
  localparam logic [UV_W-1:0]   UV_LAST   = UV_W'(UV_TICKS - 1);

  logic [HOLD_W-1:0] hold_q;
  logic [UV_W-1:0]   uv_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hold_q <= '0;
    else if (load_i)                    hold_q <= HOLD_INIT;
    else if (clear_i)                   hold_q <= '0;
    else if (in_safe_i && vcc_uv_i)     hold_q <= HOLD_INIT;
    else if (in_safe_i && hold_q != '0) hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        uv_cnt_q <= '0;
    else if (uv_watch_i && vcc_uv_i) begin
      if (uv_cnt_q != UV_LAST)          uv_cnt_q <= uv_cnt_q + 1'b1;
    end else                            uv_cnt_q <= '0;
  end

  assign hold_done_o = (hold_q == '0);
  assign uv_trip_o   = uv_watch_i && vcc_uv_i && (uv_cnt_q == UV_LAST);

  AST_HOLD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= HOLD_INIT) else $error("hold overrun"); // R3
  AST_HOLD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_safe_i && vcc_uv_i && !clear_i |=> !hold_done_o) else $error("hold not restarted"); // R3
  AST_UV_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uv_watch_i |=> uv_cnt_q == '0) else $error("uv count stale"); // R9
endmodule

// File: rtl/lin_sel_window.sv
module lin_sel_window #(
  parameter int SEL_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_run_i,
  input  logic en_s_i,
  input  logic en_q_i,
  input  logic txd_s_i,
  output logic busy_o,
  output logic pick_o,
  output logic pick_doze_o
);
  localparam int WIN_W = $clog2(SEL_TICKS + 1);
  localparam logic [WIN_W-1:0] WIN_INIT = WIN_W'(SEL_TICKS);

  logic [WIN_W-1:0] win_q;
  logic             en_fall;

  assign en_fall = en_q_i && !en_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            win_q <= '0;
    else if (!in_run_i)     win_q <= '0;
    else if (win_q != '0)   win_q <= en_s_i ? '0 : win_q - 1'b1;
    else if (en_fall)       win_q <= WIN_INIT;
  end

  assign busy_o      = (win_q != '0);
  assign pick_o      = in_run_i && (win_q == WIN_W'(1)) && !en_s_i;
  assign pick_doze_o = !txd_s_i;

  AST_WIN_OUTSIDE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_run_i |=> !busy_o) else $error("window open outside run"); // R6
  AST_WIN_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && en_s_i |=> !busy_o) else $error("window not cancelled"); // R8
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int RST_TICKS   = 4000,
  parameter int UV_TICKS    = 8,
  parameter int SEL_TICKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       vcc_uv_i,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       wake_req_i,
  output logic [2:0] mode_o,
  output logic       reg_en_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       nres_o,
  output logic       rxd_low_o
);
  lin_mode_e mode_q, mode_d;
  logic en_s, en_q, txd_s;
  logic hold_done, uv_trip, win_busy, pick, pick_doze;
  logic load_hold, clr_hold, wake_set, wake_clr, wake_q;
  logic live;

  lin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(en_i), .q_o(en_s));
  lin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_txd (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(txd_i), .q_o(txd_s));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_s;

  lin_reset_timer #(.RST_TICKS(RST_TICKS), .UV_TICKS(UV_TICKS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(load_hold), .clear_i(clr_hold),
    .in_safe_i(mode_q == MODE_SAFE),
    .uv_watch_i(mode_q == MODE_RUN || mode_q == MODE_QUIET),
    .vcc_uv_i(vcc_uv_i),
    .hold_done_o(hold_done), .uv_trip_o(uv_trip));

  lin_sel_window #(.SEL_TICKS(SEL_TICKS)) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_run_i(mode_q == MODE_RUN),
    .en_s_i(en_s), .en_q_i(en_q), .txd_s_i(txd_s),
    .busy_o(win_busy), .pick_o(pick), .pick_doze_o(pick_doze));

  always_comb begin
    mode_d    = mode_q;
    load_hold = 1'b0;
    clr_hold  = 1'b0;
    wake_set  = 1'b0;
    wake_clr  = 1'b0;
    if (!supply_ok_i) begin
      mode_d   = MODE_OFF;
      wake_clr = 1'b1;
    end else begin
      unique case (mode_q)
        MODE_OFF: begin
          mode_d    = MODE_SAFE;
          load_hold = 1'b1;
        end
        MODE_SAFE: begin
          if (hold_done && !vcc_uv_i && en_s) begin
            mode_d   = MODE_RUN;
            wake_clr = 1'b1;
          end
        end
        MODE_RUN: begin
          if (uv_trip) begin
            mode_d    = MODE_SAFE;
            load_hold = 1'b1;
          end else if (pick) begin
            mode_d = pick_doze ? MODE_DOZE : MODE_QUIET;
          end
        end
        MODE_QUIET: begin
          if (uv_trip) begin
            mode_d    = MODE_SAFE;
            load_hold = 1'b1;
          end else if (wake_req_i) begin
            mode_d   = MODE_SAFE;
            clr_hold = 1'b1;
            wake_set = 1'b1;
          end else if (en_s) begin
            mode_d = MODE_RUN;
          end
        end
        MODE_DOZE: begin
          if (wake_req_i || en_s) begin
            mode_d    = MODE_SAFE;
            load_hold = 1'b1;
            wake_set  = wake_req_i;
          end
        end
        default: mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      wake_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (wake_clr)      wake_q <= 1'b0;
      else if (wake_set) wake_q <= 1'b1;
    end
  end

  assign live      = (mode_q == MODE_SAFE) || (mode_q == MODE_RUN) || (mode_q == MODE_QUIET);
  assign mode_o    = mode_q;
  assign reg_en_o  = live;
  assign tx_en_o   = (mode_q == MODE_RUN) && !win_busy;
  assign rx_en_o   = (mode_q == MODE_RUN);
  assign nres_o    = live && hold_done;
  assign rxd_low_o = wake_q || (mode_q == MODE_DOZE);

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd4) else $error("illegal mode"); // R12
  AST_SUPPLY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> mode_o == 3'd0 && !reg_en_o && !nres_o && !rxd_low_o) else $error("supply drop"); // R2
  AST_POWER_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd0 && supply_ok_i |=> mode_o == 3'd1 && reg_en_o && !nres_o) else $error("power up"); // R1
  AST_TX_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> rx_en_o && nres_o && reg_en_o) else $error("tx outside run"); // R5
  AST_DOZE_OUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd4 |-> !reg_en_o && !nres_o && rxd_low_o && !tx_en_o) else $error("sleep outputs"); // R7
  AST_HOLD_NO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd1 && !nres_o |=> mode_o != 3'd2) else $error("run during hold"); // R4
  AST_QUIET_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd3 && supply_ok_i && !uv_trip && wake_req_i |=> mode_o == 3'd1 && nres_o && rxd_low_o)
    else $error("silent wake"); // R10
endmodule

// File: tb/sim_lin_mode_ctrl.sv
module sim_lin_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RST_T = 20;
  localparam int UV_T  = 4;
  localparam int SEL_T = 5;

  logic clk = 0, rst_ni = 0;
  logic supply_ok = 0, vcc_uv = 0, en = 0, txd = 1, wake = 0;
  logic [2:0] mode;
  logic reg_en, tx_en, rx_en, nres, rxd_low;
  int checks = 0, errors = 0;
  string cur_req = "R12";

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_mode_ctrl #(.RST_TICKS(RST_T), .UV_TICKS(UV_T), .SEL_TICKS(SEL_T), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .vcc_uv_i(vcc_uv),
    .en_i(en), .txd_i(txd), .wake_req_i(wake), .mode_o(mode), .reg_en_o(reg_en),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .nres_o(nres), .rxd_low_o(rxd_low));

  // behavioural reference: 0 off, 1 fail-safe, 2 normal, 3 silent, 4 sleep
  int m_mode, m_hold, m_uv, m_win;
  bit m_wake, m_en1, m_en2, m_en3, m_tx1, m_tx2;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_hold = 0; m_uv = 0; m_win = 0; m_wake = 0;
      m_en1 = 0; m_en2 = 0; m_en3 = 0; m_tx1 = 1; m_tx2 = 1;
    end else begin
      int nm;
      bit ld, cl, watch, trip, pick;
      nm = m_mode; ld = 0; cl = 0;
      watch = (m_mode == 2 || m_mode == 3);
      trip  = watch && vcc_uv && (m_uv == UV_T - 1);
      pick  = (m_mode == 2) && (m_win == 1) && !m_en2;
      if (!supply_ok) begin nm = 0; m_wake = 0; end
      else if (m_mode == 0) begin nm = 1; ld = 1; end
      else if (m_mode == 1) begin
        if (m_hold == 0 && !vcc_uv && m_en2) begin nm = 2; m_wake = 0; end
      end else if (m_mode == 2) begin
        if (trip) begin nm = 1; ld = 1; end
        else if (pick) nm = m_tx2 ? 3 : 4;
      end else if (m_mode == 3) begin
        if (trip) begin nm = 1; ld = 1; end
        else if (wake) begin nm = 1; cl = 1; m_wake = 1; end
        else if (m_en2) nm = 2;
      end else begin
        if (wake) begin nm = 1; ld = 1; m_wake = 1; end
        else if (m_en2) begin nm = 1; ld = 1; end
      end
      if (ld) m_hold = RST_T;
      else if (cl) m_hold = 0;
      else if (m_mode == 1 && vcc_uv) m_hold = RST_T;
      else if (m_mode == 1 && m_hold > 0) m_hold--;
      if (watch && vcc_uv) begin if (m_uv < UV_T - 1) m_uv++; end
      else m_uv = 0;
      if (m_mode != 2) m_win = 0;
      else if (m_win != 0) m_win = m_en2 ? 0 : m_win - 1;
      else if (m_en3 && !m_en2) m_win = SEL_T;
      m_mode = nm;
      m_en3 = m_en2; m_en2 = m_en1; m_en1 = en;
      m_tx2 = m_tx1; m_tx1 = txd;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_ni) begin
    bit live;
    live = (m_mode >= 1 && m_mode <= 3);
    chk(cur_req, "mode",    mode,    m_mode);
    chk(cur_req, "reg_en",  reg_en,  live);
    chk(cur_req, "tx_en",   tx_en,   (m_mode == 2 && m_win == 0));
    chk(cur_req, "rx_en",   rx_en,   (m_mode == 2));
    chk(cur_req, "nres",    nres,    (live && m_hold == 0));
    chk(cur_req, "rxd_low", rxd_low, (m_wake || m_mode == 4));
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    chk("R12", "reset mode", mode, 0);
    chk("R12", "reset nres", nres, 0);
    rst_ni = 1;
    step(2);
    // R1 / R3 / R4: power up with slow regulator, enable asserted early
    cur_req = "R1"; supply_ok = 1; vcc_uv = 1;
    step(1);
    chk("R1", "mode after supply", mode, 1);
    chk("R1", "reg_en", reg_en, 1);
    step(4);
    cur_req = "R4"; en = 1; vcc_uv = 0;
    step(RST_T - 2);
    chk("R3", "nres during hold", nres, 0);
    chk("R4", "mode during hold", mode, 1);
    cur_req = "R5";
    step(6);
    chk("R5", "mode normal", mode, 2);
    chk("R5", "tx_en", tx_en, 1);
    // R8: short enable drop
    cur_req = "R8"; en = 0; step(2); en = 1; step(8);
    chk("R8", "still normal", mode, 2);
    chk("R8", "tx_en back", tx_en, 1);
    // R6: silent
    cur_req = "R6"; en = 0; txd = 1; step(12);
    chk("R6", "silent", mode, 3);
    chk("R6", "nres", nres, 1);
    // R13: enable from silent
    cur_req = "R13"; en = 1; step(5);
    chk("R13", "normal from silent", mode, 2);
    // R7: sleep with simultaneous edges
    cur_req = "R7"; en = 0; txd = 0; step(12);
    chk("R7", "sleep", mode, 4);
    chk("R7", "reg off", reg_en, 0);
    chk("R7", "rxd low", rxd_low, 1);
    // R11: wake from sleep
    cur_req = "R11"; txd = 1; wake = 1; step(1); wake = 0;
    chk("R11", "fail-safe after wake", mode, 1);
    chk("R11", "rxd low", rxd_low, 1);
    chk("R11", "nres low", nres, 0);
    en = 1; step(RST_T + 4);
    chk("R11", "normal after hold", mode, 2);
    chk("R10", "rxd cleared", rxd_low, 0);
    // R7: enable falls before TXD, inside window
    cur_req = "R7"; en = 0; step(2); txd = 0; step(12);
    chk("R7", "late txd sleep", mode, 4);
    // R13: enable in sleep, no wake flag
    cur_req = "R13"; txd = 1; en = 1; step(3);
    chk("R13", "fail-safe from sleep", mode, 1);
    chk("R13", "no wake flag", rxd_low, 0);
    step(RST_T + 2);
    chk("R13", "normal after hold", mode, 2);
    // R10: wake from silent
    cur_req = "R10"; en = 0; step(12);
    wake = 1; step(1); wake = 0;
    chk("R10", "fail-safe", mode, 1);
    chk("R10", "nres high", nres, 1);
    chk("R10", "rxd low", rxd_low, 1);
    en = 1; step(5);
    chk("R10", "normal", mode, 2);
    // R9: short undervoltage ignored, long one trips
    cur_req = "R9"; vcc_uv = 1; step(UV_T - 1); vcc_uv = 0; step(3);
    chk("R9", "short pulse ignored", mode, 2);
    vcc_uv = 1; step(UV_T + 1);
    chk("R9", "tripped", mode, 1);
    chk("R9", "nres low", nres, 0);
    vcc_uv = 0; step(RST_T + 3);
    chk("R9", "recovered", mode, 2);
    // R2: supply loss
    cur_req = "R2"; supply_ok = 0; step(1);
    chk("R2", "unpowered", mode, 0);
    chk("R2", "nres", nres, 0);
    step(3);
    finish_run();
  end
endmodule